// File: doc/BRIEF.md
# Eight-Channel LED Dimming PWM

This block drives eight LED lines, each with its own pulse-width modulator. A host sets each line through a single configuration byte. The upper three bits of that byte choose what the line does: it can be switched off, held at a fixed level, or ramped up or down. The lower five bits are a brightness code. A nonlinear table expands each 5-bit code into a 7-bit compare level between 0 and 64. One free-running 6-bit timer is shared by all lines, and each line compares the timer against its level to make its pulse. The table gives fine steps at low brightness and coarse steps at high brightness, so perceived brightness rises more evenly from code to code.

Two shared registers control ramping. A 5-bit floor/ceiling value gives the stop point for the modes that ramp to a programmable level. A 4-bit pace value sets how often a ramping code steps. When a line ramps, its current code is written back into its own configuration byte, so the host can read the present level at any time. A pace of zero freezes every ramp.

Each line is a small state machine with five states. CH_OFF is the off state. CH_STEADY holds a fixed level. CH_FALL counts the code down. CH_RISE counts the code up. CH_PARKED is the state a ramp enters once it reaches its stop point. Every write to a line's byte moves that line into an entry state chosen from the new mode: 000 goes to CH_OFF, 001 to 011 go to CH_STEADY, 100 and 101 go to CH_FALL, and 110 and 111 go to CH_RISE. On each step pulse, CH_FALL and CH_RISE move the code one count toward the target. The line takes the transition to CH_PARKED on the step that lands on the target, or on the first step if the code is already at or beyond the target. CH_OFF, CH_STEADY and CH_PARKED leave only when the line's byte is written again.

Top module: `led_pwm_bank`

## Requirements
- R1: While a line is not off, its output is high during exactly L of every 64 timer ticks, where L is the code expanded as follows: codes 0 to 16 give L equal to the code, codes 17 to 24 give 16+2×(code−16), codes 25 to 30 give 32+4×(code−24), and code 31 gives 64. The output is high while the timer value is below L.
- R2: Mode 000 (bits 7:5 of the line byte) keeps the output low whatever the code is.
- R3: Modes 001, 010 and 011 hold the written code unchanged at every pace setting.
- R4: Mode 100 lowers the code by one on each step and stops at 0.
- R5: Mode 101 lowers the code by one on each step and stops at the limit value. A code already at or below the limit stays unchanged.
- R6: Mode 110 raises the code by one on each step and stops at 31.
- R7: Mode 111 raises the code by one on each step and stops at the limit value.
- R8: With a nonzero pace P, successive steps are P × PERIODS_PER_UNIT × 64 × CLK_PER_TICK clock cycles apart.
- R9: A pace of 0 produces no steps, so a ramping code holds its value.
- R10: Register map. Addresses 0 to 7 are the line bytes and read back as {mode[7:5], current code[4:0]}. Address 8 is the limit, stored in bits 4:0. Address 9 is the pace, stored in bits 3:0. Unused bits read as 0, and any other address reads as 0.
- R11: A write to one line, and that line's ramping, leave the other lines' codes and outputs unchanged.
- R12: After reset, every register reads 0 and every output is low.
- R13: Code 31 on a line that is not off keeps its output high for the entire period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| pwm_out | output | CHANNELS | One PWM output per line |

## Verification
A write on one clock edge is visible at rd_data from the next edge. A new level reaches pwm_out one edge later, because the compare result is registered. The bench therefore waits one extra cycle after each write before it opens a measurement window, and each window covers exactly 64 cycles (one tick per cycle), so the count of high samples equals the level whatever the timer phase. Ramp results are read after a wait longer than the worst-case step count times the step period plus one period for the unknown starting phase. The step interval is measured between two successive code changes seen at the read port, so the phase of the first step does not matter.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

    localparam int CODE_W  = 5;
    localparam int LEVEL_W = 7;
    localparam int TIMER_W = 6;
    localparam int MODE_W  = 3;

    typedef enum logic [2:0] {
        CH_OFF,
        CH_STEADY,
        CH_FALL,
        CH_RISE,
        CH_PARKED
    } ch_state_e;

    // Expand a 5-bit brightness code to a compare level in 0..64.
    function automatic logic [LEVEL_W-1:0] code_to_level(input logic [CODE_W-1:0] c);
        logic [LEVEL_W-1:0] cx;
        cx = {2'b00, c};
        if (c <= 5'd16)
            return cx;
        else if (c <= 5'd24)
            return 7'd16 + ((cx - 7'd16) << 1);
        else if (c <= 5'd30)
            return 7'd32 + ((cx - 7'd24) << 2);
        else
            return 7'd64;
    endfunction

    // Pick the state a line enters when its byte is written.
    function automatic ch_state_e entry_state(input logic [MODE_W-1:0] m);
        if (m == 3'b000)
            return CH_OFF;
        else if (!m[2])
            return CH_STEADY;
        else if (!m[1])
            return CH_FALL;
        else
            return CH_RISE;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import led_pwm_pkg::*;
#(
    parameter int CLK_PER_TICK     = 16,
    parameter int PERIODS_PER_UNIT = 128,
    parameter int SPD_W            = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SPD_W-1:0]   spd,
    output logic [TIMER_W-1:0] timer_o,
    output logic               step_o
);
    localparam int PRE_W = $clog2(CLK_PER_TICK + 1);
    localparam int PER_W = $clog2(PERIODS_PER_UNIT + 1);
    localparam logic [TIMER_W-1:0] TIMER_TOP = {TIMER_W{1'b1}};

    logic tick;

    generate
        if (CLK_PER_TICK == 1) begin : g_no_pre
            assign tick = 1'b1;
        end else begin : g_pre
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pre_q <= '0;
                else if (pre_q == PRE_W'(CLK_PER_TICK - 1))
                    pre_q <= '0;
                else
                    pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PRE_W'(CLK_PER_TICK - 1));
        end
    endgenerate

    logic [TIMER_W-1:0] timer_q;
    logic [PER_W-1:0]   per_q;
    logic [SPD_W-1:0]   unit_q;
    logic               period_end, unit_end, step_hit;

    assign period_end = tick && (timer_q == TIMER_TOP);
    assign unit_end   = period_end && (per_q == PER_W'(PERIODS_PER_UNIT - 1));
    assign step_hit   = unit_end && (spd != '0) && (unit_q >= spd - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            per_q   <= '0;
            unit_q  <= '0;
        end else begin
            if (tick)
                timer_q <= timer_q + 1'b1;
            if (unit_end)
                per_q <= '0;
            else if (period_end)
                per_q <= per_q + 1'b1;
            if (spd == '0 || step_hit)
                unit_q <= '0;
            else if (unit_end)
                unit_q <= unit_q + 1'b1;
        end
    end

    assign timer_o = timer_q;
    assign step_o  = step_hit;

    assert_timer_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && timer_q == TIMER_TOP) |=> (timer_q == '0));

    assert_timer_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(timer_q));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import led_pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [7:0]         wr_byte,
    input  logic [CODE_W-1:0]  lim,
    input  logic               step,
    input  logic [TIMER_W-1:0] timer,
    output logic [7:0]         cfg_o,
    output logic               pwm_o
);
    ch_state_e          state_q, state_n;
    logic [MODE_W-1:0]  mode_q, mode_n;
    logic [CODE_W-1:0]  code_q, code_n;
    logic [CODE_W-1:0]  tgt;
    logic [LEVEL_W-1:0] level;
    logic               pwm_q;

    // Stop point of a ramp: limit for odd modes, else the end of the range.
    assign tgt = mode_q[0] ? lim : (mode_q[1] ? 5'd31 : 5'd0);

    always_comb begin
        state_n = state_q;
        mode_n  = mode_q;
        code_n  = code_q;
        if (wr_hit) begin
            mode_n  = wr_byte[7:5];
            code_n  = wr_byte[4:0];
            state_n = entry_state(wr_byte[7:5]);
        end else begin
            unique case (state_q)
                CH_OFF, CH_STEADY, CH_PARKED: ;
                CH_FALL: begin
                    if (step) begin
                        if (code_q > tgt) begin
                            code_n = code_q - 1'b1;
                            if (code_q - 1'b1 <= tgt)
                                state_n = CH_PARKED;
                        end else begin
                            state_n = CH_PARKED;
                        end
                    end
                end
                CH_RISE: begin
                    if (step) begin
                        if (code_q < tgt) begin
                            code_n = code_q + 1'b1;
                            if (code_q + 1'b1 >= tgt)
                                state_n = CH_PARKED;
                        end else begin
                            state_n = CH_PARKED;
                        end
                    end
                end
                default: state_n = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            mode_q  <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_n;
            mode_q  <= mode_n;
            code_q  <= code_n;
        end
    end

    assign level = code_to_level(code_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pwm_q <= 1'b0;
        else
            pwm_q <= (state_q != CH_OFF) && ({1'b0, timer} < level);
    end

    assign pwm_o = pwm_q;
    assign cfg_o = {mode_q, code_q};

    assert_off_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |=> !pwm_o);

    assert_full_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_OFF && code_q == 5'd31) |=> pwm_o);

    assert_steady_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STEADY && !wr_hit) |=> $stable(code_q));

    assert_fall_no_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_FALL && !wr_hit) |=> (code_q <= $past(code_q)));

    assert_rise_no_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RISE && !wr_hit) |=> (code_q >= $past(code_q)));

    assert_parked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PARKED && !wr_hit) |=> $stable(code_q));

    assert_no_step_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_hit) |=> $stable(code_q));

endmodule

// File: rtl/led_pwm_bank.sv
module led_pwm_bank
    import led_pwm_pkg::*;
#(
    parameter int CHANNELS         = 8,
    parameter int ADDR_W           = 4,
    parameter int CLK_PER_TICK     = 16,
    parameter int PERIODS_PER_UNIT = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [7:0]          rd_data,
    output logic [CHANNELS-1:0] pwm_out
);
    localparam int SPD_W = 4;
    localparam logic [ADDR_W-1:0] LIM_ADDR = ADDR_W'(CHANNELS);
    localparam logic [ADDR_W-1:0] SPD_ADDR = ADDR_W'(CHANNELS + 1);

    logic [CODE_W-1:0]  lim_q;
    logic [SPD_W-1:0]   spd_q;
    logic [TIMER_W-1:0] timer;
    logic               step;
    logic [7:0]         cfg [CHANNELS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
            spd_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == LIM_ADDR)
                lim_q <= wr_data[CODE_W-1:0];
            if (wr_addr == SPD_ADDR)
                spd_q <= wr_data[SPD_W-1:0];
        end
    end

    pwm_timebase #(
        .CLK_PER_TICK    (CLK_PER_TICK),
        .PERIODS_PER_UNIT(PERIODS_PER_UNIT),
        .SPD_W           (SPD_W)
    ) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .spd    (spd_q),
        .timer_o(timer),
        .step_o (step)
    );

    generate
        for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
            pwm_channel u_ch (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_en && (wr_addr == ADDR_W'(i))),
                .wr_byte(wr_data),
                .lim    (lim_q),
                .step   (step),
                .timer  (timer),
                .cfg_o  (cfg[i]),
                .pwm_o  (pwm_out[i])
            );
        end
    endgenerate

    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == LIM_ADDR)
            rd_data = {3'b000, lim_q};
        else if (rd_addr == SPD_ADDR)
            rd_data = {4'b0000, spd_q};
        else
            for (int i = 0; i < CHANNELS; i++)
                if (rd_addr == ADDR_W'(i))
                    rd_data = cfg[i];
    end

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_q == '0) |-> !step);

    assert_reset_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0));

endmodule

// File: tb/led_pwm_bank_test.sv
module led_pwm_bank_test;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [3:0]     rd_addr = '0;
    logic [7:0]     rd_data;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    led_pwm_bank #(
        .CHANNELS(NCH), .ADDR_W(4), .CLK_PER_TICK(1), .PERIODS_PER_UNIT(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_level(input int c);
        if (c <= 16) return c;
        if (c <= 24) return 16 + 2 * (c - 16);
        if (c <= 30) return 32 + 4 * (c - 24);
        return 64;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 4'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic duty(input int ch, output int n);
        n = 0;
        @(negedge clk);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            n += int'(pwm_out[ch]);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        chk("R12 outputs low", int'(pwm_out), 0);
        for (int a = 0; a < 10; a++) begin
            rd(a, v);
            chk("R12 register zero", v, 0);
        end
    endtask

    task automatic t_map();
        int codes[8] = '{0, 5, 16, 17, 24, 25, 30, 31};
        int n;
        wr(9, 1);
        foreach (codes[i]) begin
            wr(0, 8'h20 | codes[i]);
            duty(0, n);
            chk(codes[i] == 31 ? "R13 full duty" : "R1 level map", n, ref_level(codes[i]));
        end
        wr(9, 0);
    endtask

    task automatic t_off();
        int n;
        wr(3, 8'h1F);
        duty(3, n);
        chk("R2 mode off", n, 0);
    endtask

    task automatic t_hold();
        int v, n;
        wr(9, 1);
        wr(4, 8'h47);
        idle(600);
        rd(4, v);
        chk("R3 steady code", v, 8'h47);
        duty(4, n);
        chk("R3 steady duty", n, 7);
    endtask

    task automatic t_dec_zero();
        int v;
        wr(9, 1);
        wr(1, 8'h99);
        idle(3500);
        rd(1, v);
        chk("R4 fall to zero", v, 8'h80);
        idle(400);
        rd(1, v);
        chk("R4 stays zero", v, 8'h80);
    endtask

    task automatic t_dec_lim();
        int v;
        wr(8, 10);
        wr(9, 1);
        wr(1, 8'hB4);
        idle(1600);
        rd(1, v);
        chk("R5 fall to limit", v, 8'hAA);
        wr(2, 8'hA4);
        idle(400);
        rd(2, v);
        chk("R5 below limit unchanged", v, 8'hA4);
    endtask

    task automatic t_inc_full();
        int v, n;
        wr(9, 1);
        wr(5, 8'hC0);
        idle(4200);
        rd(5, v);
        chk("R6 rise to 31", v, 8'hDF);
        idle(300);
        rd(5, v);
        chk("R6 stays 31", v, 8'hDF);
        duty(5, n);
        chk("R13 ramped full duty", n, 64);
    endtask

    task automatic t_inc_lim();
        int v;
        wr(8, 12);
        wr(9, 1);
        wr(6, 8'hE3);
        idle(1400);
        rd(6, v);
        chk("R7 rise to limit", v, 8'hEC);
    endtask

    task automatic t_rate();
        int v, prev, t0, t1, k;
        wr(9, 2);
        wr(7, 8'hC0);
        rd(7, prev);
        k = 0;
        while (k < 2000) begin
            @(negedge clk); rd(7, v); k++;
            if (v != prev) break;
        end
        t0 = cyc; prev = v; k = 0;
        while (k < 2000) begin
            @(negedge clk); rd(7, v); k++;
            if (v != prev) break;
        end
        t1 = cyc;
        chk("R8 step interval", t1 - t0, 256);
    endtask

    task automatic t_freeze();
        int v;
        wr(9, 0);
        wr(7, 8'hC5);
        idle(1000);
        rd(7, v);
        chk("R9 pace zero frozen", v, 8'hC5);
    endtask

    task automatic t_regmap();
        int v;
        wr(8, 8'hFF);
        rd(8, v);
        chk("R10 limit field", v, 8'h1F);
        wr(9, 8'hFF);
        rd(9, v);
        chk("R10 pace field", v, 8'h0F);
        wr(9, 0);
        rd(12, v);
        chk("R10 unmapped address", v, 0);
        wr(0, 8'hA5);
        rd(0, v);
        chk("R10 line byte", v, 8'hA5);
    endtask

    task automatic t_indep();
        int v, n;
        wr(9, 1);
        wr(3, 8'h29);
        wr(2, 8'hC0);
        idle(1000);
        rd(3, v);
        chk("R11 neighbour code", v, 8'h29);
        duty(3, n);
        chk("R11 neighbour duty", n, 9);
        wr(9, 0);
    endtask

    initial begin
        t_reset();
        t_map();
        t_off();
        t_hold();
        t_dec_zero();
        t_dec_lim();
        t_inc_full();
        t_inc_lim();
        t_rate();
        t_freeze();
        t_regmap();
        t_indep();
        done = 1;
        summary();
        $finish;
    end
endmodule